// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable model of a synchronous static RAM that stores 36-bit words split into four 9-bit byte lanes. The address, write data and every control input except the output enable and the burst-order select are registered on the rising clock edge. A read is flow-through: there is no output register, so the addressed word appears on the read port in the same cycle in which its address was registered.

A cycle begins when either of two address-status strobes is asserted. The processor-side strobe is honoured only while the primary enable is low. The controller-side strobe is honoured in every case, and it deselects the chip when the enables do not select it. After a cycle has started, the advance strobe steps a 2-bit burst counter through the four words of an aligned group. The counter follows a linear or an interleaved order, picked by a static select input. Writes use either a global write, which stores all lanes, or a write enable combined with per-lane selects. The tri-state data pad is split into a data-in port, a data-out port and an output-valid flag, and an asynchronous output enable gates the flag.

Top module: `burst_sram`

## Requirements
- R1: At a rising edge, when the processor strobe `adspN` is low, `ce1N` is low, `ce2` is high and `ce3N` is low, a cycle starts at the address on `addr`. From the next cycle, with `oeN` low and no write, `rdValid` is 1 and `rdData` holds that word.
- R2: At an edge with `adspN` low, `ce1N` high and `adscN` high, the processor strobe is ignored. The active or deselected state and the current burst address stay unchanged.
- R3: At an edge with `adscN` low and `ce1N` high, the chip is deselected, whatever the state of `adspN`.
- R4: A strobe-started cycle selects the chip only when `ce1N`=0, `ce2`=1 and `ce3N`=0. With any other combination the chip is deselected.
- R5: At an edge inside an active cycle with `gwN` low, all four lanes of the current word are written from `wrData`, whatever `weN` and `byteN` are.
- R6: At an edge inside an active cycle with `gwN` high and `weN` low, lane i (bits 9i+8..9i) is written only when `byteN[i]` is low. The other lanes keep their contents.
- R7: Write data is taken on the same edge as the write controls and the address. A cycle that writes leaves `rdValid` at 0.
- R8: `rdValid` is combinational in `oeN`. It is 0 whenever `oeN` is 1, and it follows the cycle state as soon as `oeN` returns to 0, with no clock edge needed.
- R9: The read is flow-through. In the cycle after the edge that registered an address, `rdData` shows the stored word at that address, including a word written at that same edge.
- R10: With `interleave`=0, each edge with `advN` low inside an active cycle sets the low two address bits to (start + k) mod 4 for the k-th advance. The upper bits stay fixed.
- R11: With `interleave`=1, the low two address bits follow start XOR k for the k-th advance.
- R12: While the chip is deselected, `rdValid` stays 0, and `advN` and the write controls have no effect until a strobe starts a new cycle.
- R13: While `rst` is high and after it falls, the chip is deselected and `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Word address, registered at a cycle start |
| wrData | input | 36 | Write data, registered |
| adspN | input | 1 | Processor-side address strobe, active low |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3N | input | 1 | Third chip enable, active low |
| gwN | input | 1 | Global write, active low |
| weN | input | 1 | Byte-gated write enable, active low |
| byteN | input | 4 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| rdData | output | 36 | Flow-through read word |
| rdValid | output | 1 | Pad drive enable for rdData |

## Verification
The properties take it for granted that `interleave` only changes while no burst is in progress. They also take it for granted that all registered inputs are at known levels at every edge, which the burst-order and write checks rely on. The stimulus changes inputs only on the falling edge, and sets `interleave` between bursts while both strobes are idle. The only input it toggles mid-cycle is `oeN`, the one input the design treats as asynchronous. Words read back are always written first, so no check compares against uninitialised storage.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic             load;     // selected cycle start at this edge
    logic             step;     // burst advance at this edge
    logic [LANES-1:0] laneWe;   // lanes written at this edge
    logic             readOk;   // registered: current cycle is an active read
  } strobes_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             weN,
  input  logic [LANES-1:0] byteN,
  output strobes_t         strobes
);
  logic active;
  logic readOk;
  logic procStart;
  logic ctrlStart;
  logic newCycle;
  logic chipSel;
  logic nextActive;
  logic nextWrite;
  logic [LANES-1:0] laneWe;

  always_comb begin
    procStart  = !adspN && !ce1N;
    ctrlStart  = !procStart && !adscN;
    newCycle   = procStart || ctrlStart;
    chipSel    = !ce1N && ce2 && !ce3N;
    if (newCycle) begin
      nextActive = chipSel;
    end else begin
      nextActive = active;
    end
    nextWrite = nextActive && (!gwN || !weN);
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneWe[g] = nextActive && (!gwN || (!weN && !byteN[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      readOk <= 1'b0;
    end else begin
      active <= nextActive;
      readOk <= nextActive && !nextWrite;
    end
  end

  always_comb begin
    strobes.load   = newCycle && chipSel;
    strobes.step   = !newCycle && active && !advN;
    strobes.laneWe = rst ? '0 : laneWe;
    strobes.readOk = readOk;
  end

  AST_FULL_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!adspN && !ce1N && ce2 && !ce3N) |=> active);                         // R1
  AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!adspN && ce1N && adscN) |=> (active == $past(active)));              // R2
  AST_CTRL_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (!adscN && ce1N) |=> !active);                                         // R3
  AST_ENABLE_DECODE: assert property (@(posedge clk) disable iff (rst)
    (!adspN && !ce1N && (!ce2 || ce3N)) |=> !active);                      // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!active && adspN && adscN) |=> (!active && !readOk));                 // R12
  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (!gwN || !weN) |=> !readOk);                                           // R7
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              interleave,
  input  strobes_t          strobes,
  output logic [WORD_W-1:0] rdData
);
  logic [AW-1:0]      baseReg;
  logic [BURST_W-1:0] idxReg;
  logic [AW-1:0]      nextBase;
  logic [BURST_W-1:0] nextIdx;
  logic [AW-1:0]      wrAddr;
  logic [AW-1:0]      rdAddr;
  logic [WORD_W-1:0]  mem [DEPTH];

  function automatic logic [BURST_W-1:0] orderLow(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] count,
    input logic               xorMode
  );
    if (xorMode) begin
      return start ^ count;
    end
    return start + count;
  endfunction

  always_comb begin
    nextBase = strobes.load ? addr : baseReg;
    if (strobes.load) begin
      nextIdx = '0;
    end else if (strobes.step) begin
      nextIdx = idxReg + 1'b1;
    end else begin
      nextIdx = idxReg;
    end
    wrAddr = {nextBase[AW-1:BURST_W], orderLow(nextBase[BURST_W-1:0], nextIdx, interleave)};
    rdAddr = {baseReg[AW-1:BURST_W], orderLow(baseReg[BURST_W-1:0], idxReg, interleave)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0;
      idxReg  <= '0;
    end else begin
      baseReg <= nextBase;
      idxReg  <= nextIdx;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLaneWr
      always_ff @(posedge clk) begin
        if (strobes.laneWe[g]) begin
          mem[wrAddr][g*LANE_W +: LANE_W] <= wrData[g*LANE_W +: LANE_W];
        end
      end
      AST_LANE_STORE: assert property (@(posedge clk) disable iff (rst)
        strobes.laneWe[g] |=> (rdData[g*LANE_W +: LANE_W] == $past(wrData[g*LANE_W +: LANE_W]))); // R6
    end
  endgenerate

  assign rdData = mem[rdAddr];

  AST_GLOBAL_FILL: assert property (@(posedge clk) disable iff (rst)
    (strobes.laneWe == '1) |=> (rdData == $past(wrData)));                 // R5
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && !strobes.load) |=> $stable(rdAddr[AW-1:BURST_W]));    // R10
  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && interleave && $stable(interleave)) |=>
      ((rdAddr[BURST_W-1:0] ^ baseReg[BURST_W-1:0]) == idxReg));           // R11
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              weN,
  input  logic [LANES-1:0]  byteN,
  input  logic              oeN,
  input  logic              interleave,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  strobes_t strobes;

  burst_sram_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .adspN   (adspN),
    .adscN   (adscN),
    .advN    (advN),
    .ce1N    (ce1N),
    .ce2     (ce2),
    .ce3N    (ce3N),
    .gwN     (gwN),
    .weN     (weN),
    .byteN   (byteN),
    .strobes (strobes)
  );

  burst_sram_datapath #(.DEPTH(DEPTH)) uData (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wrData     (wrData),
    .interleave (interleave),
    .strobes    (strobes),
    .rdData     (rdData)
  );

  assign rdValid = strobes.readOk && !oeN;

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    oeN |-> !rdValid);                                                     // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rdValid);                                                     // R13
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [35:0] wrData = '0;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic gwN = 1'b1, weN = 1'b1;
  logic [3:0] byteN = 4'hF;
  logic oeN = 1'b0, interleave = 1'b0;
  logic [35:0] rdData;
  logic rdValid;

  int checks = 0, fails = 0;

  // reference model state
  logic [35:0] refMem [DEPTH];
  bit mAct = 0, mWr = 0;
  int mBase = 0, mIdx = 0;

  burst_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData),
    .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .weN(weN), .byteN(byteN), .oeN(oeN),
    .interleave(interleave), .rdData(rdData), .rdValid(rdValid)
  );

  always #5 clk = ~clk;

  function automatic int modelAddr();
    int low;
    if (interleave) low = (mBase % 4) ^ mIdx;
    else low = ((mBase % 4) + mIdx) % 4;
    return (mBase / 4) * 4 + low;
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOutputs(input string tag);
    bit expValid;
    logic [35:0] expData;
    expValid = mAct && !mWr && !oeN;
    check(tag, {35'd0, rdValid}, {35'd0, expValid});
    if (mAct) begin
      expData = refMem[modelAddr()];
      if (!$isunknown(expData)) check(tag, rdData, expData);
    end
  endtask

  // one clock: update the model at the edge, compare at the falling edge
  task automatic tick(input string tag);
    bit pS, cS;
    int wa;
    @(posedge clk);
    pS = !adspN && !ce1N;
    cS = !pS && !adscN;
    if (rst) begin
      mAct = 0; mWr = 0; mBase = 0; mIdx = 0;
    end else begin
      if (pS || cS) begin
        if (!ce1N && ce2 && !ce3N) begin
          mAct = 1; mBase = int'(addr); mIdx = 0;
        end else begin
          mAct = 0;
        end
      end else if (mAct && !advN) begin
        mIdx = (mIdx + 1) % 4;
      end
      if (mAct) begin
        wa = modelAddr();
        if (!gwN) refMem[wa] = wrData;
        else if (!weN) begin
          for (int i = 0; i < 4; i++)
            if (!byteN[i]) refMem[wa][i*9 +: 9] = wrData[i*9 +: 9];
        end
        mWr = !gwN || !weN;
      end else begin
        mWr = 0;
      end
    end
    @(negedge clk);
    compareOutputs(tag);
  endtask

  task automatic idle();
    adspN = 1; adscN = 1; advN = 1; gwN = 1; weN = 1; byteN = 4'hF;
    ce1N = 0; ce2 = 1; ce3N = 0;
  endtask

  task automatic writeWord(input string tag, input int a, input logic [35:0] d,
                           input bit useGlobal, input logic [3:0] lanes);
    idle(); adscN = 0; addr = AW'(a); wrData = d;
    if (useGlobal) gwN = 0; else begin weN = 0; byteN = lanes; end
    tick(tag);
    idle();
  endtask

  task automatic readStart(input string tag, input int a);
    idle(); adspN = 0; addr = AW'(a);
    tick(tag);
    idle();
  endtask

  task automatic advance(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      idle(); advN = 0; tick(tag);
    end
    idle();
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 4; i++) refMem[0] = 'x;
    @(negedge clk);
    tick("R13"); tick("R13");
    check("R13", {35'd0, rdValid}, 36'd0);
    rst = 0;
    @(negedge clk);
    tick("R13");

    // global write ignores byte selects and write enable
    writeWord("R5", 8, 36'h9_1234_5678, 1, 4'hF);
    tick("R7");
    readStart("R9", 8);
    // byte-gated write, lanes 0 and 2
    writeWord("R6", 8, 36'hA_AAAA_AAAA, 0, 4'b1010);
    tick("R6");
    readStart("R6", 8);
    // write then read in consecutive cycles (flow-through)
    writeWord("R9", 9, 36'h5_0F0F_0F0F, 1, 4'h0);
    readStart("R9", 9);

    // fill an aligned group for the burst tests
    for (int i = 0; i < 4; i++)
      writeWord("R1", 16 + i, 36'h1_0000_0000 + 36'(i * 36'h1111), 1, 4'h0);
    interleave = 0;
    readStart("R1", 18);
    advance("R10", 3);
    advance("R10", 1);
    interleave = 1;
    readStart("R11", 17);
    advance("R11", 3);
    readStart("R11", 19);
    advance("R11", 2);
    interleave = 0;

    // processor strobe blocked by primary enable
    readStart("R2", 16);
    idle(); adspN = 0; ce1N = 1; addr = AW'(9); tick("R2");
    idle(); tick("R2");
    // controller strobe with primary enable high deselects
    idle(); adscN = 0; adspN = 0; ce1N = 1; addr = AW'(8); tick("R3");
    idle(); tick("R3");
    // deselected: advance and writes do nothing
    advance("R12", 2);
    idle(); gwN = 0; wrData = 36'hF_FFFF_FFFF; tick("R12");
    idle(); weN = 0; byteN = 4'h0; tick("R12");
    idle();
    // processor strobe while deselected and blocked stays deselected
    idle(); adspN = 0; ce1N = 1; tick("R2");
    readStart("R12", 16);

    // enable decode
    idle(); adspN = 0; ce2 = 0; addr = AW'(8); tick("R4");
    idle(); tick("R4");
    readStart("R4", 8);
    idle(); adscN = 0; ce3N = 1; addr = AW'(8); tick("R4");
    idle(); tick("R4");
    readStart("R4", 9);

    // asynchronous output enable
    readStart("R8", 8);
    oeN = 1; #1;
    check("R8", {35'd0, rdValid}, 36'd0);
    oeN = 0; #1;
    check("R8", {35'd0, rdValid}, 36'd1);
    tick("R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule